// File: doc/BRIEF.md
# Sequential Device Resource Allocator

This block hands out address windows and interrupt line ranges to devices that register one after another. A registration gives a requested base address, a window size, a requested first interrupt line and a line count. A field requested as zero is filled in from a free pointer, and that pointer then moves past the granted range. A field requested as non-zero is kept as given and leaves its pointer alone. After the interrupt pointer moves forward, it steps over a configurable set of reserved line numbers. If it lands at or above a configurable ceiling, a sticky fatal flag is raised.

Each granted registration is written at the tail of an internal device table, so reading the table by index lists devices in the order they registered. A full table refuses further registrations and raises a sticky overflow flag. An initialisation strobe loads the starting values of both free pointers.

The controller is a four-state machine:
- ST_IDLE accepts an initialisation or a registration.
- ST_GRANT resolves both fields and advances the pointers.
- ST_SKIP steps the interrupt pointer over reserved lines, one per cycle.
- ST_DONE writes the table and pulses `done`.

Transitions:
- ST_IDLE goes to ST_GRANT when a registration is accepted.
- ST_GRANT goes to ST_SKIP when the interrupt field is auto-assigned, and to ST_DONE otherwise.
- ST_SKIP stays in ST_SKIP while the pointer sits on a reserved line, and goes to ST_DONE once it does not.
- ST_DONE always returns to ST_IDLE.

Top module: `dev_res_alloc`

## Requirements
- R1: After reset, `busy`, `done`, `irq_fatal`, `tbl_overflow`, `tbl_count`, `grant_base` and `grant_irq` are all zero.
- R2: A registration with `req_base` zero is granted the current free base, and the free base then grows by `req_size`.
- R3: A registration with non-zero `req_base` is granted that base unchanged, and the free base is left as it was.
- R4: Interrupt lines are auto-assigned only when `req_irq` is zero and `req_irq_cnt` is non-zero. The grant is the free interrupt pointer, which then grows by the count. Otherwise `grant_irq` equals `req_irq`, and the pointer is unchanged.
- R5: After an auto-assignment advances the interrupt pointer, the pointer is incremented once per cycle while it equals any reserved line (default 9, 10 and 20). The next auto grant therefore never starts on the value the advance landed on if that value was reserved.
- R6: When the interrupt pointer, after advancing and skipping, is greater than or equal to `IRQ_MAX` (default 64), `irq_fatal` is set. It then stays set until reset, and the grant still completes.
- R7: Each completed registration is stored at index `tbl_count`, and `tbl_count` then increments. Reading index i returns the granted base, size, granted first line and count of the i-th registration. An index at or above `tbl_count` reads as zero.
- R8: A registration presented while `tbl_count` equals `DEPTH` (default 16) produces no `done`. It changes neither the table nor the count, and it sets `tbl_overflow`, which then stays set until reset.
- R9: `init_valid` in ST_IDLE loads the free base from `init_base` and the free interrupt pointer from `init_irq`. A registration presented in the same cycle is ignored.
- R10: `done` is a single-cycle pulse. It comes 2 clock edges after the accepting edge when the interrupt field is not auto-assigned, and 3 + k edges after it when it is, where k is the number of reserved lines skipped. `busy` is high from the cycle after acceptance through the `done` cycle, and a registration presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Load both free pointers (honoured in ST_IDLE) |
| init_base | input | ADDR_W | Starting free base |
| init_irq | input | IRQ_W | Starting free interrupt line |
| req_valid | input | 1 | Registration strobe |
| req_base | input | ADDR_W | Requested base, zero for auto |
| req_size | input | ADDR_W | Window size |
| req_irq | input | IRQ_W | Requested first line, zero for auto |
| req_irq_cnt | input | CNT_W | Number of interrupt lines |
| busy | output | 1 | Registration in progress |
| done | output | 1 | One-cycle completion pulse |
| grant_base | output | ADDR_W | Granted base, valid with done |
| grant_irq | output | IRQ_W | Granted first line, valid with done |
| irq_fatal | output | 1 | Sticky interrupt exhaustion flag |
| tbl_overflow | output | 1 | Sticky table-full drop flag |
| tbl_count | output | $clog2(DEPTH+1) | Number of stored devices |
| rd_idx | input | $clog2(DEPTH) | Table read index |
| rd_base | output | ADDR_W | Stored base at rd_idx |
| rd_size | output | ADDR_W | Stored size at rd_idx |
| rd_irq | output | IRQ_W | Stored first line at rd_idx |
| rd_irq_cnt | output | CNT_W | Stored line count at rd_idx |

## Verification
The `done` pulse and its grant values arrive 2 edges after the accepting edge for requests without interrupt auto-assignment, and 3 + k edges after it otherwise. The bench counts edges from acceptance and compares that count with the latency its model predicts from the reserved-line walk. `irq_fatal` is checked in the `done` cycle. `tbl_overflow` and the unchanged count are checked a few cycles after a dropped request. Table contents are read combinationally, with the index driven and then sampled away from the clock edge.

// File: rtl/dra_pkg.sv
package dra_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_SKIP  = 2'd2,
        ST_DONE  = 2'd3
    } alloc_state_e;
endpackage

// File: rtl/dra_base_ptr.sv
module dra_base_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic [ADDR_W-1:0] adv_amt,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (adv)
            ptr <= ptr + adv_amt;
    end

    // R3: the free base only moves on a load or an advance
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(ptr));
endmodule

// File: rtl/dra_irq_ptr.sv
module dra_irq_ptr #(
    parameter int                       IRQ_W    = 8,
    parameter int                       CNT_W    = 4,
    parameter int                       NUM_RSV  = 3,
    parameter logic [NUM_RSV*IRQ_W-1:0] RSV_LIST = {8'd20, 8'd10, 8'd9},
    parameter int                       IRQ_MAX  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IRQ_W-1:0] load_val,
    input  logic             adv,
    input  logic [CNT_W-1:0] adv_cnt,
    input  logic             step,
    output logic [IRQ_W-1:0] ptr,
    output logic             on_rsv,
    output logic             at_limit
);
    localparam logic [IRQ_W:0] LIMIT = (IRQ_W+1)'(IRQ_MAX);

    logic [NUM_RSV-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_RSV; gi++) begin : g_rsv
            assign hit[gi] = (ptr == RSV_LIST[gi*IRQ_W +: IRQ_W]);
        end
    endgenerate

    assign on_rsv   = |hit;
    assign at_limit = ({1'b0, ptr} >= LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (adv)
            ptr <= ptr + IRQ_W'(adv_cnt);
        else if (step)
            ptr <= ptr + 1'b1;
    end

    // R5: a skip step moves the pointer by exactly one line
    p_skip_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !adv) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/dra_dev_table.sv
module dra_dev_table #(
    parameter int ADDR_W = 32,
    parameter int IRQ_W  = 8,
    parameter int CNT_W  = 4,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_base,
    input  logic [ADDR_W-1:0]          wr_size,
    input  logic [IRQ_W-1:0]           wr_irq,
    input  logic [CNT_W-1:0]           wr_cnt,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [ADDR_W-1:0]          rd_base,
    output logic [ADDR_W-1:0]          rd_size,
    output logic [IRQ_W-1:0]           rd_irq,
    output logic [CNT_W-1:0]           rd_cnt,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CT_W  = $clog2(DEPTH+1);

    logic [ADDR_W-1:0] base_mem [DEPTH];
    logic [ADDR_W-1:0] size_mem [DEPTH];
    logic [IRQ_W-1:0]  irq_mem  [DEPTH];
    logic [CNT_W-1:0]  cnt_mem  [DEPTH];

    logic in_use;

    assign full   = (count == CT_W'(DEPTH));
    assign in_use = ({1'b0, rd_idx} < (IDX_W+1)'(count));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_en && !full) begin
            base_mem[IDX_W'(count)] <= wr_base;
            size_mem[IDX_W'(count)] <= wr_size;
            irq_mem[IDX_W'(count)]  <= wr_irq;
            cnt_mem[IDX_W'(count)]  <= wr_cnt;
            count <= count + 1'b1;
        end
    end

    always_comb begin
        rd_base = in_use ? base_mem[rd_idx] : '0;
        rd_size = in_use ? size_mem[rd_idx] : '0;
        rd_irq  = in_use ? irq_mem[rd_idx]  : '0;
        rd_cnt  = in_use ? cnt_mem[rd_idx]  : '0;
    end

    // R8: the controller never writes into a full table
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R7: each write appends exactly one entry
    p_append_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> (count == $past(count) + 1'b1));
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(count));
endmodule

// File: rtl/dev_res_alloc.sv
module dev_res_alloc
    import dra_pkg::*;
#(
    parameter int                       ADDR_W   = 32,
    parameter int                       IRQ_W    = 8,
    parameter int                       CNT_W    = 4,
    parameter int                       DEPTH    = 16,
    parameter int                       NUM_RSV  = 3,
    parameter logic [NUM_RSV*IRQ_W-1:0] RSV_LIST = {8'd20, 8'd10, 8'd9},
    parameter int                       IRQ_MAX  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init_valid,
    input  logic [ADDR_W-1:0]          init_base,
    input  logic [IRQ_W-1:0]           init_irq,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_base,
    input  logic [ADDR_W-1:0]          req_size,
    input  logic [IRQ_W-1:0]           req_irq,
    input  logic [CNT_W-1:0]           req_irq_cnt,
    output logic                       busy,
    output logic                       done,
    output logic [ADDR_W-1:0]          grant_base,
    output logic [IRQ_W-1:0]           grant_irq,
    output logic                       irq_fatal,
    output logic                       tbl_overflow,
    output logic [$clog2(DEPTH+1)-1:0] tbl_count,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [ADDR_W-1:0]          rd_base,
    output logic [ADDR_W-1:0]          rd_size,
    output logic [IRQ_W-1:0]           rd_irq,
    output logic [CNT_W-1:0]           rd_irq_cnt
);
    alloc_state_e st_q, st_d;

    logic [ADDR_W-1:0] r_base, r_size;
    logic [IRQ_W-1:0]  r_irq;
    logic [CNT_W-1:0]  r_cnt;
    logic [ADDR_W-1:0] g_base;
    logic [IRQ_W-1:0]  g_irq;
    logic              fatal_q, ovf_q;

    logic [ADDR_W-1:0] free_base;
    logic [IRQ_W-1:0]  free_irq;
    logic              irq_on_rsv, irq_at_limit, tbl_full;

    logic in_idle, do_init, accept, drop;
    logic auto_base, auto_irq;
    logic base_adv, irq_adv, irq_step, tbl_wr;

    assign in_idle   = (st_q == ST_IDLE);
    assign do_init   = in_idle && init_valid;
    assign accept    = in_idle && req_valid && !init_valid && !tbl_full;
    assign drop      = in_idle && req_valid && !init_valid && tbl_full;
    assign auto_base = (r_base == '0);
    assign auto_irq  = (r_irq == '0) && (r_cnt != '0);
    assign base_adv  = (st_q == ST_GRANT) && auto_base;
    assign irq_adv   = (st_q == ST_GRANT) && auto_irq;
    assign irq_step  = (st_q == ST_SKIP) && irq_on_rsv;
    assign tbl_wr    = (st_q == ST_DONE);

    dra_base_ptr #(.ADDR_W(ADDR_W)) u_base_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_init),
        .load_val (init_base),
        .adv      (base_adv),
        .adv_amt  (r_size),
        .ptr      (free_base)
    );

    dra_irq_ptr #(
        .IRQ_W    (IRQ_W),
        .CNT_W    (CNT_W),
        .NUM_RSV  (NUM_RSV),
        .RSV_LIST (RSV_LIST),
        .IRQ_MAX  (IRQ_MAX)
    ) u_irq_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_init),
        .load_val (init_irq),
        .adv      (irq_adv),
        .adv_cnt  (r_cnt),
        .step     (irq_step),
        .ptr      (free_irq),
        .on_rsv   (irq_on_rsv),
        .at_limit (irq_at_limit)
    );

    dra_dev_table #(
        .ADDR_W (ADDR_W),
        .IRQ_W  (IRQ_W),
        .CNT_W  (CNT_W),
        .DEPTH  (DEPTH)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_base (g_base),
        .wr_size (r_size),
        .wr_irq  (g_irq),
        .wr_cnt  (r_cnt),
        .rd_idx  (rd_idx),
        .rd_base (rd_base),
        .rd_size (rd_size),
        .rd_irq  (rd_irq),
        .rd_cnt  (rd_irq_cnt),
        .count   (tbl_count),
        .full    (tbl_full)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = ST_GRANT;
            ST_GRANT: st_d = auto_irq ? ST_SKIP : ST_DONE;
            ST_SKIP:  if (!irq_on_rsv) st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Request capture, grants and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_base  <= '0;
            r_size  <= '0;
            r_irq   <= '0;
            r_cnt   <= '0;
            g_base  <= '0;
            g_irq   <= '0;
            fatal_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (accept) begin
                r_base <= req_base;
                r_size <= req_size;
                r_irq  <= req_irq;
                r_cnt  <= req_irq_cnt;
            end
            if (drop)
                ovf_q <= 1'b1;
            if (st_q == ST_GRANT) begin
                g_base <= auto_base ? free_base : r_base;
                g_irq  <= auto_irq ? free_irq : r_irq;
            end
            if ((st_q == ST_SKIP) && !irq_on_rsv && irq_at_limit)
                fatal_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy         = (st_q != ST_IDLE);
        done         = (st_q == ST_DONE);
        grant_base   = g_base;
        grant_irq    = g_irq;
        irq_fatal    = fatal_q;
        tbl_overflow = ovf_q;
    end

    // R10: completion is a single-cycle pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: exhaustion flag is sticky
    p_fatal_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fatal |=> irq_fatal);
    // R8: overflow flag is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_overflow |=> tbl_overflow);
    // R5: leaving the skip walk, the pointer is off every reserved line
    p_skip_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SKIP) && !irq_on_rsv) |=> !irq_on_rsv);
    // R8: a dropped request leaves the table count unchanged
    p_drop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(tbl_count));
endmodule

// File: tb/test_dev_res_alloc.sv
`timescale 1ns/1ps
module test_dev_res_alloc;
    localparam int AW = 32, IW = 8, CW = 4, DEP = 16, MAXI = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_valid = 1'b0;
    logic [AW-1:0] init_base = '0;
    logic [IW-1:0] init_irq = '0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_base = '0, req_size = '0;
    logic [IW-1:0] req_irq = '0;
    logic [CW-1:0] req_irq_cnt = '0;
    logic busy, done, irq_fatal, tbl_overflow;
    logic [AW-1:0] grant_base, rd_base, rd_size;
    logic [IW-1:0] grant_irq, rd_irq;
    logic [CW-1:0] rd_irq_cnt;
    logic [4:0] tbl_count;
    logic [3:0] rd_idx = '0;

    always #2.5 clk = ~clk;

    dev_res_alloc #(
        .ADDR_W(AW), .IRQ_W(IW), .CNT_W(CW), .DEPTH(DEP), .NUM_RSV(3),
        .RSV_LIST({8'd20, 8'd10, 8'd9}), .IRQ_MAX(MAXI)
    ) i_dev_res_alloc (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_base(init_base),
        .init_irq(init_irq), .req_valid(req_valid), .req_base(req_base),
        .req_size(req_size), .req_irq(req_irq), .req_irq_cnt(req_irq_cnt),
        .busy(busy), .done(done), .grant_base(grant_base), .grant_irq(grant_irq),
        .irq_fatal(irq_fatal), .tbl_overflow(tbl_overflow), .tbl_count(tbl_count),
        .rd_idx(rd_idx), .rd_base(rd_base), .rd_size(rd_size), .rd_irq(rd_irq),
        .rd_irq_cnt(rd_irq_cnt)
    );

    int checks = 0, failures = 0;
    logic [AW-1:0] m_base = '0;
    logic [IW-1:0] m_irq = '0;
    int m_count = 0;
    bit m_fatal = 0, m_ovf = 0;
    logic [AW-1:0] e_base [DEP];
    logic [AW-1:0] e_size [DEP];
    logic [IW-1:0] e_irq  [DEP];
    logic [CW-1:0] e_cnt  [DEP];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_rsv(input logic [IW-1:0] v);
        return (v == 8'd9) || (v == 8'd10) || (v == 8'd20);
    endfunction

    task automatic do_init(input logic [AW-1:0] b, input logic [IW-1:0] q);
        @(negedge clk);
        init_valid = 1'b1; init_base = b; init_irq = q;
        @(negedge clk);
        init_valid = 1'b0;
        m_base = b; m_irq = q;
    endtask

    // Registration with model prediction; latency counted in edges from acceptance
    task automatic do_reg(input logic [AW-1:0] b, input logic [AW-1:0] s,
                          input logic [IW-1:0] q, input logic [CW-1:0] c);
        int lat, k;
        bit seen, full;
        logic [AW-1:0] gb;
        logic [IW-1:0] gi;
        full = (m_count == DEP);
        k = 0;
        gb = (b == '0) ? m_base : b;
        gi = q;
        if (!full) begin
            if (b == '0) m_base = m_base + s;
            if (q == '0 && c != '0) begin
                gi = m_irq;
                m_irq = m_irq + IW'(c);
                while (is_rsv(m_irq)) begin m_irq = m_irq + 1'b1; k++; end
                if (m_irq >= MAXI) m_fatal = 1;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_base = b; req_size = s; req_irq = q; req_irq_cnt = c;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; seen = 0;
        while (lat < 12) begin
            if (done) begin seen = 1; break; end
            @(negedge clk); lat++;
        end
        if (full) begin
            m_ovf = 1;
            chk("R8", "done on full table", 64'(seen), 64'd0);
            chk("R8", "overflow flag", 64'(tbl_overflow), 64'd1);
            chk("R8", "count after drop", 64'(tbl_count), 64'(DEP));
        end else begin
            chk("R10", "done seen", 64'(seen), 64'd1);
            chk("R10", "latency", 64'(lat), 64'((q == '0 && c != '0) ? 3 + k : 2));
            chk((b == '0) ? "R2" : "R3", "grant_base", 64'(grant_base), 64'(gb));
            chk("R4", "grant_irq", 64'(grant_irq), 64'(gi));
            chk("R6", "irq_fatal", 64'(irq_fatal), 64'(m_fatal));
            e_base[m_count] = gb; e_size[m_count] = s;
            e_irq[m_count] = gi; e_cnt[m_count] = c;
            m_count++;
            @(negedge clk);
            chk("R10", "done single pulse", 64'(done), 64'd0);
            chk("R7", "tbl_count", 64'(tbl_count), 64'(m_count));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 64'(busy), 0);
        chk("R1", "done", 64'(done), 0);
        chk("R1", "irq_fatal", 64'(irq_fatal), 0);
        chk("R1", "tbl_overflow", 64'(tbl_overflow), 0);
        chk("R1", "tbl_count", 64'(tbl_count), 0);
        chk("R1", "grant_base", 64'(grant_base), 0);
        chk("R1", "grant_irq", 64'(grant_irq), 0);

        do_init(32'h1000_0000, 8'd5);                 // R9
        do_reg('0, 32'h1000, '0, 4'd2);                // R2 R4: base 0x10000000, irq 5
        do_reg(32'h2000_0000, 32'h100, '0, 4'd0);      // R3 R4: no auto irq, grant 0
        do_reg('0, 32'h200, 8'd33, 4'd1);              // R4: requested irq kept
        do_reg('0, 32'h400, '0, 4'd2);                 // R5: 7 -> 9 -> 10 -> 11
        do_reg('0, 32'h80, '0, 4'd1);                  // R5: grant 11

        // R9: init wins over a simultaneous request, which is ignored
        @(negedge clk);
        init_valid = 1'b1; init_base = 32'h3000_0000; init_irq = 8'd18;
        req_valid = 1'b1; req_base = '0; req_size = 32'h40; req_irq = '0; req_irq_cnt = 4'd1;
        @(negedge clk);
        init_valid = 1'b0; req_valid = 1'b0;
        m_base = 32'h3000_0000; m_irq = 8'd18;
        repeat (4) @(negedge clk);
        chk("R9", "no done for ignored request", 64'(done), 0);
        chk("R9", "count unchanged", 64'(tbl_count), 64'(m_count));
        do_reg('0, 32'h1000, '0, 4'd2);                // R9 R5: grant 18, 20 skipped -> 21

        // R10: request while busy is ignored
        begin
            int lat;
            logic [AW-1:0] gb;
            logic [IW-1:0] gi;
            gb = m_base; gi = m_irq;
            @(negedge clk);
            req_valid = 1'b1; req_base = '0; req_size = 32'h100; req_irq = '0; req_irq_cnt = 4'd1;
            @(negedge clk);
            chk("R10", "busy after accept", 64'(busy), 1);
            req_size = 32'h7777; req_irq_cnt = 4'd3;
            @(negedge clk);
            req_valid = 1'b0;
            lat = 2;
            while (!done && lat < 12) begin @(negedge clk); lat++; end
            chk("R10", "busy-ignore latency", 64'(lat), 3);
            chk("R10", "busy-ignore grant_base", 64'(grant_base), 64'(gb));
            chk("R10", "busy-ignore grant_irq", 64'(grant_irq), 64'(gi));
            e_base[m_count] = gb; e_size[m_count] = 32'h100; e_irq[m_count] = gi; e_cnt[m_count] = 4'd1;
            m_count++;
            m_base = m_base + 32'h100; m_irq = m_irq + 1'b1;
            repeat (3) @(negedge clk);
            chk("R10", "one entry only", 64'(tbl_count), 64'(m_count));
        end
        do_reg('0, 32'h20, '0, 4'd1);                  // R2: pointer moved only by 0x100

        // R6: exhaustion
        chk("R6", "fatal clear before", 64'(irq_fatal), 0);
        do_init(m_base, 8'd62);
        do_reg('0, 32'h10, '0, 4'd2);                  // 62 -> 64 fatal
        do_reg('0, 32'h10, 8'd3, 4'd1);                // R6 sticky
        chk("R6", "fatal sticky", 64'(irq_fatal), 1);

        // Random registrations until the table is full
        while (m_count < DEP) begin
            logic [AW-1:0] b, s;
            logic [IW-1:0] q;
            logic [CW-1:0] c;
            b = ($urandom % 2) ? '0 : {4'h4, 16'($urandom), 12'h000};
            s = 32'(($urandom % 16) + 1) << 8;
            q = ($urandom % 2) ? '0 : IW'(($urandom % 40) + 1);
            c = CW'($urandom % 4);
            do_reg(b, s, q, c);
        end

        // R7: enumeration order equals registration order
        for (int i = 0; i < DEP; i++) begin
            @(negedge clk);
            rd_idx = 4'(i);
            #1;
            chk("R7", "rd_base", 64'(rd_base), 64'(e_base[i]));
            chk("R7", "rd_size", 64'(rd_size), 64'(e_size[i]));
            chk("R7", "rd_irq", 64'(rd_irq), 64'(e_irq[i]));
            chk("R7", "rd_irq_cnt", 64'(rd_irq_cnt), 64'(e_cnt[i]));
        end

        // R8: drop on full table
        chk("R8", "overflow clear before", 64'(tbl_overflow), 0);
        do_reg('0, 32'h55, '0, 4'd1);
        do_reg(32'h7000_0000, 32'h55, 8'd2, 4'd1);
        @(negedge clk);
        rd_idx = 4'(DEP - 1);
        #1;
        chk("R8", "last entry untouched", 64'(rd_base), 64'(e_base[DEP-1]));
        chk("R8", "overflow sticky", 64'(tbl_overflow), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule